// File: doc/BRIEF.md
# Soft-Start and Fault Restart Sequencer

This block orders the start-up of a primary-side switching controller. A digital accumulator stands in for the soft-start capacitor voltage. A supply monitor with a wide gap between its release and lockout codes gates the whole sequence. While the supply is locked out, the accumulator is held at zero and the gate driver is inhibited.

Once the supply is released, the accumulator charges in steps of fixed size. The block turns the accumulator into a ceiling on switching duty that rises from 0% to 72%. A shutdown-level overcurrent flag starts a recovery cycle. The block emits a one-cycle restart pulse, which hands PWM timing back to the internal oscillator. It then inhibits the driver while the accumulator drains at a slower slope than it charges. When the accumulator falls below the low level, the driver is released and the ramp starts again.

Charge and drain steps are both paced by a run-time divider. This lets the ramp time be matched to the switching frequency.

Top module: `softstart_seq`

## Requirements
- R1: While locked out, a supply code strictly greater than 100 releases the lockout, and `enable_ref` is high after the next clock edge. Codes of 100 or less keep the block locked.
- R2: While released, a supply code strictly less than 80 locks the block at the next edge. Any code from 80 to 255 keeps it released.
- R3: While locked out (and after reset), `enable_ref` is 0, `drv_inhibit` is 1, `duty_limit` is 0 and `restart_pulse` is 0. A release always starts the ramp from an accumulator value of zero.
- R4: While ramping, the accumulator gains 7 counts on every tick and saturates at 20480 counts. After a release, the tick falls on every (`tick_div`+1)-th clock edge, counting the release edge as edge 0.
- R5: `duty_limit` is 0 while the accumulator is at or below 4096 counts. Above that it is floor((acc-4096)*72/16384), so it reaches 72 at the clamp and never exceeds 72.
- R6: A high `ocp_shutdown` seen at an edge while ramping sets `drv_inhibit` and `restart_pulse` after that edge. The accumulator is held on that edge, and `restart_pulse` lasts exactly one cycle.
- R7: While draining, the accumulator loses 5 counts on every tick. At the first edge where it is below 4096, the block returns to ramping: `drv_inhibit` falls, and charging restarts from that value.
- R8: `ocp_shutdown` is ignored while draining. It produces no restart pulse and does not change the drain length.
- R9: Lockout overrides both ramping and draining. The accumulator is cleared, and the next release ramps from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_code | input | 8 | Digitised supply voltage, 10 codes per volt |
| ocp_shutdown | input | 1 | Shutdown-level overcurrent flag |
| tick_div | input | 8 | Step divider: one step every tick_div+1 cycles |
| enable_ref | output | 1 | High when the supply lockout is released |
| duty_limit | output | 7 | Maximum duty in percent, 0 to 72 |
| restart_pulse | output | 1 | One-cycle pulse at the start of a fault cycle |
| drv_inhibit | output | 1 | Forces the gate driver low |

## Verification
The supply comparator is tested with every one of the 256 codes from both the locked and the released state. This separates the release threshold from the lockout threshold and shows the hold band between them.

The ramp is followed cycle by cycle from zero to the clamp for four divider settings. This checks the step size, the tick phase, saturation, and the duty mapping at every accumulator value the ramp reaches.

A fault is raised at the clamp, and the drain is followed cycle by cycle to its exact length. The same fault is then repeated with extra overcurrent pulses during the drain. This shows whether those pulses are ignored or restart the sequence.

A final run pulls the supply low in the middle of a drain. This confirms that the lockout takes priority and that the next ramp starts from zero.

// File: rtl/softstart_seq.sv
`timescale 1ns/1ps
module softstart_seq #(
  parameter int SUP_W     = 8,
  parameter int ON_CODE   = 100,
  parameter int OFF_CODE  = 80,
  parameter int ACC_W     = 16,
  parameter int LOW_LVL   = 4096,
  parameter int CLAMP_LVL = 20480,
  parameter int CHG_STEP  = 7,
  parameter int DIS_STEP  = 5,
  parameter int DIV_W     = 8,
  parameter int DUTY_MAX  = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_code,
  input  logic             ocp_shutdown,
  input  logic [DIV_W-1:0] tick_div,
  output logic             enable_ref,
  output logic [6:0]       duty_limit,
  output logic             restart_pulse,
  output logic             drv_inhibit
);

  localparam int PW = ACC_W + 7;
  localparam int SPAN = CLAMP_LVL - LOW_LVL;
  localparam logic [ACC_W-1:0] LOW   = ACC_W'(LOW_LVL);
  localparam logic [ACC_W-1:0] CLAMP = ACC_W'(CLAMP_LVL);
  localparam logic [ACC_W-1:0] DSTEP = ACC_W'(DIS_STEP);

  typedef enum logic [1:0] {S_LOCK, S_RAMP, S_DRAIN} st_t;

  st_t              st;
  logic [ACC_W-1:0] acc;
  logic [DIV_W-1:0] cnt;
  logic [ACC_W:0]   up;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    quot;
  logic             tick, sup_hi, sup_lo;

  assign sup_hi = supply_code > SUP_W'(ON_CODE);
  assign sup_lo = supply_code < SUP_W'(OFF_CODE);
  assign tick   = (st != S_LOCK) && (cnt == tick_div);
  assign up     = {1'b0, acc} + (ACC_W+1)'(CHG_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_LOCK;
      acc           <= '0;
      cnt           <= '0;
      restart_pulse <= 1'b0;
    end else begin
      restart_pulse <= 1'b0;
      case (st)
        S_LOCK: begin
          acc <= '0;
          cnt <= '0;
          if (sup_hi) st <= S_RAMP;
        end
        default: begin
          cnt <= tick ? '0 : cnt + DIV_W'(1);
          if (sup_lo) begin
            st  <= S_LOCK;
            acc <= '0;
          end else if (st == S_RAMP) begin
            if (ocp_shutdown) begin
              st            <= S_DRAIN;
              restart_pulse <= 1'b1;
            end else if (tick) begin
              acc <= (up > {1'b0, CLAMP}) ? CLAMP : up[ACC_W-1:0];
            end
          end else begin
            if (acc < LOW) st <= S_RAMP;
            else if (tick) acc <= (acc >= DSTEP) ? acc - DSTEP : '0;
          end
        end
      endcase
    end
  end

  assign enable_ref  = (st != S_LOCK);
  assign drv_inhibit = (st != S_RAMP);

  assign prod = PW'(acc - LOW) * PW'(DUTY_MAX);
  assign quot = prod / PW'(SPAN);
  assign duty_limit = (acc > LOW) ? quot[6:0] : 7'd0;

  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_ref && sup_hi) |=> enable_ref);
  p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_ref && sup_lo) |=> !enable_ref);
  p_lock_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable_ref) |-> (duty_limit == 7'd0 && drv_inhibit));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= CLAMP);
  p_duty_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    duty_limit <= 7'(DUTY_MAX));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);
  p_pulse_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> drv_inhibit);
  p_drain_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && $past(st) == S_DRAIN) |-> acc <= $past(acc));
  p_drain_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && $past(st) == S_DRAIN) |-> !restart_pulse);

endmodule

// File: tb/softstart_seq_bench.sv
`timescale 1ns/1ps
module softstart_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] supply_code = 8'd0;
  logic       ocp_shutdown = 1'b0;
  logic [7:0] tick_div = 8'd0;
  logic       enable_ref, restart_pulse, drv_inhibit;
  logic [6:0] duty_limit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  softstart_seq u_softstart_seq (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code),
    .ocp_shutdown(ocp_shutdown), .tick_div(tick_div),
    .enable_ref(enable_ref), .duty_limit(duty_limit),
    .restart_pulse(restart_pulse), .drv_inhibit(drv_inhibit)
  );

  function automatic int exp_duty(int a);
    return (a <= 4096) ? 0 : ((a - 4096) * 72) / 16384;
  endfunction

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic drain_run(bit extra, int start_acc);
    int len;
    ocp_shutdown = 1'b1;
    step();
    ocp_shutdown = 1'b0;
    chk(restart_pulse == 1'b1, "R6 restart pulse", int'(restart_pulse), 1);
    chk(drv_inhibit == 1'b1, "R6 inhibit on fault", int'(drv_inhibit), 1);
    chk(int'(duty_limit) == exp_duty(start_acc), "R6 acc held", int'(duty_limit), exp_duty(start_acc));
    len = 1;
    for (int j = 1; j < 10000; j++) begin
      if (extra && (j == 100 || j == 2000)) ocp_shutdown = 1'b1;
      step();
      ocp_shutdown = 1'b0;
      chk(restart_pulse == 1'b0, extra ? "R8 no pulse in drain" : "R6 pulse width", int'(restart_pulse), 0);
      if (!drv_inhibit) break;
      len++;
      chk(int'(duty_limit) == exp_duty(start_acc - 5 * j), "R7 drain duty", int'(duty_limit), exp_duty(start_acc - 5 * j));
    end
    chk(len == (start_acc - 4096) / 5 + 2, extra ? "R8 drain length" : "R7 drain length",
        len, (start_acc - 4096) / 5 + 2);
    chk(duty_limit == 7'd0, "R7 duty at release", int'(duty_limit), 0);
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    step(3);
    chk(enable_ref == 1'b0, "R3 reset enable", int'(enable_ref), 0);
    chk(drv_inhibit == 1'b1, "R3 reset inhibit", int'(drv_inhibit), 1);
    chk(duty_limit == 7'd0, "R3 reset duty", int'(duty_limit), 0);
    chk(restart_pulse == 1'b0, "R3 reset pulse", int'(restart_pulse), 0);
    rst_n = 1'b1;
    step();

    for (int c = 0; c < 256; c++) begin
      supply_code = 8'd0; step(2);
      supply_code = 8'(c); step();
      chk(enable_ref == (c > 100), "R1 release code", int'(enable_ref), int'(c > 100));
    end
    for (int c = 0; c < 256; c++) begin
      supply_code = 8'd200; step(2);
      supply_code = 8'(c); step();
      chk(enable_ref == (c >= 80), "R2 lockout code", int'(enable_ref), int'(c >= 80));
      if (c < 80) begin
        chk(drv_inhibit == 1'b1, "R3 locked inhibit", int'(drv_inhibit), 1);
        chk(duty_limit == 7'd0, "R3 locked duty", int'(duty_limit), 0);
      end
    end

    for (int p = 0; p < 4; p++) begin
      supply_code = 8'd0; step(2);
      tick_div = 8'(p);
      supply_code = 8'd200; step();
      for (int m = 1; m <= 2926 * (p + 1) + 4; m++) begin
        int a;
        step();
        a = 7 * (m / (p + 1));
        if (a > 20480) a = 20480;
        chk(int'(duty_limit) == exp_duty(a), "R4 R5 ramp duty", int'(duty_limit), exp_duty(a));
        chk(drv_inhibit == 1'b0, "R4 ramp driver free", int'(drv_inhibit), 0);
      end
      chk(duty_limit == 7'd72, "R5 clamp duty", int'(duty_limit), 72);
    end

    tick_div = 8'd0;
    step(10);
    drain_run(1'b0, 20480);
    step(1000);
    chk(int'(duty_limit) == exp_duty(4095 + 7000), "R7 recharge", int'(duty_limit), exp_duty(4095 + 7000));

    step(3000);
    drain_run(1'b1, 20480);

    step(3000);
    ocp_shutdown = 1'b1; step(); ocp_shutdown = 1'b0;
    step(50);
    supply_code = 8'd50; step();
    chk(enable_ref == 1'b0, "R9 lock in drain", int'(enable_ref), 0);
    chk(drv_inhibit == 1'b1, "R9 inhibit", int'(drv_inhibit), 1);
    chk(duty_limit == 7'd0, "R9 duty cleared", int'(duty_limit), 0);
    supply_code = 8'd200; step();
    step(700);
    chk(int'(duty_limit) == exp_duty(4900), "R9 R3 ramp from zero", int'(duty_limit), exp_duty(4900));
    chk(drv_inhibit == 1'b0, "R9 driver free", int'(drv_inhibit), 0);

    report();
  end
endmodule